// File: doc/BRIEF.md
# SDA Stuck-Low Watchdog

This block watches the data line of a two-wire serial target port for the case where the target keeps driving the line low because the controller stopped clocking in the middle of a byte or an acknowledge. In that state the controller cannot issue a start condition, so the bus cannot clear itself. The block samples the data line once per poll period, which is set as a number of clock cycles. It counts low samples that are taken while the host side is powered. A high sample, a sample taken with the host unpowered, or a write-complete event from the target clears that count. The threshold is chosen so that two legitimate transactions between write completions do not trigger it.

When the count reaches the threshold, the block clears it and issues a one-cycle reinitialise pulse to the target logic. It also bumps a saturating recovery counter and re-enters its initialisation step. On every initialisation, meaning after reset and after each recovery, the block samples the data line once. If the line is low, it raises a one-cycle request to an external stop-sequence generator. The poll timer then restarts from zero.

Top module: `sda_stuck_watchdog`

## Requirements
- R1: While reset is held and on the first clock edge after it, all outputs read zero: `unwedge_req`, `reinit_pulse`, `low_count` and `recovery_count`.
- R2: Each initialisation lasts one cycle and samples `sda_in`. `unwedge_req` is high for exactly the next cycle if that sample was 0, and is never high otherwise.
- R3: After an initialisation ends, the data line is sampled on the POLL_TICKS-th rising edge, and then every POLL_TICKS edges after that.
- R4: A sample taken with `host_on`=0 or with `sda_in`=1 sets `low_count` to 0.
- R5: A sample taken with `host_on`=1 and `sda_in`=0 raises `low_count` by one, as long as this does not reach LOW_LIMIT.
- R6: A low sample that would bring the count to LOW_LIMIT (default 3) instead sets `low_count` to 0. On that edge, `reinit_pulse` goes high for one cycle and `recovery_count` rises by one.
- R7: `wr_done`=1 on an edge sets `low_count` to 0. This takes priority over a sample on the same edge, so that sample neither counts nor triggers R6.
- R8: `recovery_count` is REC_W bits (default 16) and stays at all ones once it gets there.
- R9: The cycle in which `reinit_pulse` is high is a new initialisation: R2 applies to it, and the poll timer restarts from zero, so the next sample comes POLL_TICKS edges after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sda_in | input | 1 | Synchronised level of the serial data line |
| host_on | input | 1 | 1 while the host side (and its pull-ups) is powered |
| wr_done | input | 1 | One-cycle write-complete event from the target |
| unwedge_req | output | 1 | One-cycle request to generate a bus stop sequence |
| reinit_pulse | output | 1 | One-cycle target reinitialise command |
| low_count | output | $clog2(LOW_LIMIT+1) | Consecutive qualifying low samples |
| recovery_count | output | REC_W | Saturating number of recoveries |

## Verification
On every cycle, the assertions check these local rules:
- the timer wraps to zero after a sample and otherwise advances by one;
- `low_count` clears after a write-complete or a recovery, and steps by one after a counted low sample;
- both pulses last a single cycle, and the unwedge request follows an initialisation;
- the recovery counter increments by one or holds at its ceiling.

Only the bench scenarios can show the absolute sample edges, the full recovery period of 3·POLL_TICKS+1 edges, and the restart of the timer after a recovery. The same holds for the priority of a write-complete over a sample on the same edge, and for the counter sitting at its ceiling after many recoveries. The bench sweeps all host and line combinations cycle by cycle and compares against arithmetic expectations.

// File: rtl/sdawd_pkg.sv
// Shared types for the SDA stuck-low watchdog.
package sdawd_pkg;
    // Controller phase: one-cycle initialisation, then polling.
    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } wd_state_e;
endpackage

// File: rtl/sdawd_poll_timer.sv
// Poll timer: emits a one-cycle sample strobe every POLL_TICKS cycles.
// Assumes: clear holds the count at zero; counting starts the cycle after clear drops.
module sdawd_poll_timer #(
    parameter int POLL_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic strobe
);
    localparam int CW = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_TICKS - 1);

    logic [CW-1:0] cnt;

    // Strobe on the last tick of each period unless held clear.
    assign strobe = !clear && (cnt == LAST);

    // Tick counter, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + CW'(1);
    end

    p_strobe_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (cnt == '0));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !strobe) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/sdawd_low_tracker.sv
// Low-sample tracker: counts consecutive qualifying low samples and flags the threshold.
// Assumes: sample is a one-cycle strobe; clear (write-complete or init) wins over sample.
module sdawd_low_tracker #(
    parameter int LOW_LIMIT = 3,
    localparam int LW = $clog2(LOW_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic          sda,
    input  logic          host_on,
    output logic [LW-1:0] low_count,
    output logic          hit
);
    localparam logic [LW-1:0] TOP = LW'(LOW_LIMIT - 1);

    logic low_seen;

    // A sample counts only while powered and the line is low.
    assign low_seen = sample && !clear && host_on && !sda;
    // Threshold reached on this sample.
    assign hit = low_seen && (low_count == TOP);

    // Counter update: clear, reset on a good sample, step on a low one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) low_count <= '0;
        else if (sample && !low_seen) low_count <= '0;
        else if (hit) low_count <= '0;
        else if (low_seen) low_count <= low_count + LW'(1);
    end

    p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (low_count == '0));
    p_hit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (low_count == '0));
    p_good_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear && (sda || !host_on)) |=> (low_count == '0));
    p_incr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_seen && !hit) |=> (low_count == $past(low_count) + LW'(1)));
endmodule

// File: rtl/sdawd_sat_counter.sv
// Saturating event counter.
// Assumes: inc is a one-cycle event; the count holds at all ones.
module sdawd_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    // Increment unless already at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (inc && (count != MAXV)) count <= count + W'(1);
    end

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV) |=> (count == MAXV));
    p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (count != MAXV)) |=> (count == $past(count) + W'(1)));
endmodule

// File: rtl/sda_stuck_watchdog.sv
// SDA stuck-low watchdog top: sequences init/run, samples the data line on a
// poll strobe, and issues recovery and unwedge pulses.
// Assumes: sda_in is already synchronised; wr_done is a one-cycle event.
module sda_stuck_watchdog
    import sdawd_pkg::*;
#(
    parameter int POLL_TICKS = 1000,
    parameter int LOW_LIMIT  = 3,
    parameter int REC_W      = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sda_in,
    input  logic                           host_on,
    input  logic                           wr_done,
    output logic                           unwedge_req,
    output logic                           reinit_pulse,
    output logic [$clog2(LOW_LIMIT+1)-1:0] low_count,
    output logic [REC_W-1:0]               recovery_count
);
    wd_state_e state;
    logic      in_init;
    logic      strobe;
    logic      hit;

    assign in_init = (state == ST_INIT);

    // Phase sequencing: one init cycle, then run until a recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else if (in_init) state <= ST_RUN;
        else if (hit) state <= ST_INIT;
    end

    // Registered pulses: unwedge after a low init sample, reinit on threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unwedge_req  <= 1'b0;
            reinit_pulse <= 1'b0;
        end else begin
            unwedge_req  <= in_init && !sda_in;
            reinit_pulse <= hit;
        end
    end

    sdawd_poll_timer #(.POLL_TICKS(POLL_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (in_init),
        .strobe (strobe)
    );

    sdawd_low_tracker #(.LOW_LIMIT(LOW_LIMIT)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wr_done || in_init),
        .sample    (strobe),
        .sda       (sda_in),
        .host_on   (host_on),
        .low_count (low_count),
        .hit       (hit)
    );

    sdawd_sat_counter #(.W(REC_W)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit),
        .count (recovery_count)
    );

    p_reinit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |=> !reinit_pulse);
    p_unwedge_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unwedge_req |-> ($past(state) == ST_INIT));
    p_unwedge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unwedge_req |=> !unwedge_req);
    p_reinit_is_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |-> (state == ST_INIT));
endmodule

// File: tb/sda_stuck_watchdog_tb_top.sv
`timescale 1ns/1ps
// Bench: small configuration (period 4, threshold 3, 3-bit recovery count),
// per-cycle sweeps with arithmetically derived expectations.
module sda_stuck_watchdog_tb_top;
    localparam int P   = 4;
    localparam int L   = 3;
    localparam int RW  = 3;
    localparam int RP  = 3 * P + 1;   // edges between recoveries
    localparam int MAXR = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sda_in = 1'b1;
    logic          host_on = 1'b1;
    logic          wr_done = 1'b0;
    logic          unwedge_req;
    logic          reinit_pulse;
    logic [1:0]    low_count;
    logic [RW-1:0] recovery_count;

    int total = 0;
    int bad = 0;
    int edges = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sda_stuck_watchdog #(.POLL_TICKS(P), .LOW_LIMIT(L), .REC_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .host_on(host_on),
        .wr_done(wr_done), .unwedge_req(unwedge_req), .reinit_pulse(reinit_pulse),
        .low_count(low_count), .recovery_count(recovery_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s edge=%0d act=%0d exp=%0d", tag, edges, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        edges++;
        @(negedge clk);
    endtask

    task automatic run_to(input int e);
        while (edges < e) tick();
    endtask

    // Reset with given levels; checks the reset state (R1).
    task automatic do_reset(input bit h, input bit s);
        @(negedge clk);
        rst_n = 1'b0; host_on = h; sda_in = s; wr_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 unwedge", unwedge_req, 0);
        chk("R1 reinit", reinit_pulse, 0);
        chk("R1 low", low_count, 0);
        chk("R1 rec", recovery_count, 0);
        rst_n = 1'b1;
        edges = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Sweep all host/line combinations held constant (R2 R3 R4 R5 R6 R9).
        for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < 2; s++) begin
                bit stuck;
                stuck = (h == 1) && (s == 0);
                do_reset(h[0], s[0]);
                for (int e = 1; e <= 80; e++) begin
                    int f, exp_low, exp_re, exp_uw, exp_rec;
                    tick();
                    f = e - RP * ((e - 1) / RP);
                    exp_re  = (stuck && (e % RP == 0)) ? 1 : 0;
                    exp_uw  = (s == 0 && (e == 1 || (stuck && e > RP && ((e - 1) % RP == 0)))) ? 1 : 0;
                    exp_low = stuck ? (((f - 1) / P) % L) : 0;
                    exp_rec = stuck ? ((e / RP > MAXR) ? MAXR : e / RP) : 0;
                    chk("R6 reinit sweep", reinit_pulse, exp_re);
                    chk("R2 R9 unwedge sweep", unwedge_req, exp_uw);
                    chk("R3 R4 R5 low sweep", low_count, exp_low);
                    chk("R6 rec sweep", recovery_count, exp_rec);
                end
            end
        end

        // R7: write-complete between samples clears and delays recovery.
        do_reset(1'b1, 1'b0);
        run_to(9);
        chk("R5 low before wr", low_count, 2);
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        chk("R7 wr clears", low_count, 0);
        run_to(13); chk("R7 count resumes", low_count, 1);
        run_to(17); chk("R7 count two", low_count, 2);
        run_to(20); chk("R7 no early reinit", reinit_pulse, 0);
        run_to(21); chk("R7 R6 delayed reinit", reinit_pulse, 1);

        // R7: write-complete on the same edge as a sample wins.
        do_reset(1'b1, 1'b0);
        run_to(8);
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        chk("R7 same-edge wr", low_count, 0);
        run_to(13); chk("R7 after same-edge", low_count, 1);

        // R7: same-edge write-complete at the threshold suppresses recovery.
        do_reset(1'b1, 1'b0);
        run_to(12);
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        chk("R7 no reinit at threshold", reinit_pulse, 0);
        chk("R7 rec unchanged", recovery_count, 0);

        // R4: one unpowered sample and one high sample each clear the count.
        do_reset(1'b1, 1'b0);
        run_to(8);
        host_on = 1'b0; tick(); host_on = 1'b1;
        chk("R4 host off clears", low_count, 0);
        run_to(13); chk("R5 count after host", low_count, 1);
        run_to(16);
        sda_in = 1'b1; tick(); sda_in = 1'b0;
        chk("R4 sda high clears", low_count, 0);

        // R9: line released right after recovery -> no unwedge, timer restarted.
        do_reset(1'b1, 1'b0);
        run_to(RP);
        chk("R6 reinit", reinit_pulse, 1);
        sda_in = 1'b1; tick();
        chk("R9 no unwedge when high", unwedge_req, 0);
        sda_in = 1'b0;
        run_to(RP + P); chk("R9 no sample yet", low_count, 0);
        run_to(RP + 1 + P); chk("R9 sample after restart", low_count, 1);

        // R8: saturation after many recoveries.
        do_reset(1'b1, 1'b0);
        run_to(RP * 10);
        chk("R8 reinit still pulses", reinit_pulse, 1);
        chk("R8 saturated", recovery_count, MAXR);
        run_to(RP * 11);
        chk("R8 holds", recovery_count, MAXR);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule